// File: doc/BRIEF.md
# Framed Word Serializer with Training Frame

This block turns a parallel data word into a serial bit stream, one bit per enabled clock. Each word goes out inside a fixed-length frame: a start bit of 1, the data bits least-significant first, and then a stop bit of 0. With the default 10-bit word, a frame is 12 bits long. A bit-rate clock enable (`bit_en`) advances the stream. Twelve enabled clocks make one frame.

A training request replaces the data frame with a fixed pattern: the first half of the frame is all ones and the second half is all zeros. This pattern holds exactly one 1-to-0 transition, so a receiver can find the frame boundary without ambiguity. Ordinary data can contain several such transitions within one frame, and then the boundary can be misread.

The block samples the data word and the training request only at a frame boundary. It holds them for the rest of that frame. A `frame_start` pulse marks the first clock in which the start bit appears on the serial output.

Top module: `frame_serializer`

## Requirements
- R1: While reset is high, and after reset until the first frame begins, `ser_out` and `frame_start` are both 0. Reset is synchronous and active high.
- R2: A frame spans exactly DATA_W+2 enabled bits (12 by default). `frame_start` is high for one clock at the start of every frame, and it is 0 in every other clock.
- R3: Bit position 0 of every data frame is the start bit, value 1. It is driven in the clock where `frame_start` is high.
- R4: Bit positions 1 to DATA_W of a data frame carry `word_in` bit 0 through bit DATA_W-1, in that order (least-significant bit first).
- R5: The last bit position (DATA_W+1) of every data frame is the stop bit, value 0.
- R6: When `train_req` is sampled high at a frame boundary, that frame is (DATA_W+2)/2 ones followed by zeros for the remaining positions. With the default width this is 6 ones then 6 zeros, so the frame holds a single falling transition.
- R7: `word_in` and `train_req` are sampled only on the enabled clock that begins a frame. Changes at any other time do not affect the frame in flight; a request arriving mid-frame takes effect at the next boundary.
- R8: `ser_out` changes only on a clock edge where `bit_en` is high. On every other edge it holds its value.
- R9: The first frame after reset begins on the first clock edge with `bit_en` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word/bit clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Bit-rate clock enable, one pulse per serial bit |
| word_in | input | DATA_W | Parallel data word, sampled at the frame boundary |
| train_req | input | 1 | Training frame request, sampled at the frame boundary |
| ser_out | output | 1 | Registered serial output |
| frame_start | output | 1 | One-clock strobe while the start bit is on `ser_out` |

## Verification
Two events can fall on the same clock: the stop bit of one frame finishes, and the next frame is loaded, which samples `word_in` and `train_req`. The bench changes both inputs on the exact enabled clock of the boundary, so the new word or training request must appear in the very next frame. It also flips both inputs right after the boundary, and the frame in flight must keep the values sampled at the boundary. The bench checks every serial bit against a queue of expected bits, both with `bit_en` high on every clock and with idle clocks between enabled bits.

// File: rtl/fser_pkg.sv
package fser_pkg;

  // Kind of frame being emitted
  typedef enum logic {
    FRAME_DATA  = 1'b0,
    FRAME_TRAIN = 1'b1
  } frame_kind_e;

  // Training pattern: ones in the lower half of bit positions, zeros above
  function automatic logic train_bit(input int pos, input int ones);
    return (pos < ones);
  endfunction

endpackage

// File: rtl/fser_bit_counter.sv
module fser_bit_counter #(
  parameter int FRAME_W = 12,
  localparam int IDX_W  = $clog2(FRAME_W)
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  output logic load_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAME_W - 1);

  logic [IDX_W-1:0] idx_q;
  logic             at_last;

  assign at_last = (idx_q == LAST);
  assign load_o  = bit_en && at_last;

  // Reset parks the counter at the last position so the first enable loads
  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= LAST;
    end else if (bit_en) begin
      idx_q <= at_last ? '0 : idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/fser_frame_builder.sv
module fser_frame_builder #(
  parameter int DATA_W  = 10,
  localparam int FRAME_W = DATA_W + 2,
  localparam int ONES    = FRAME_W / 2
) (
  input  logic              [DATA_W-1:0]  word_i,
  input  fser_pkg::frame_kind_e           kind_i,
  output logic              [FRAME_W-1:0] frame_o
);
  logic [FRAME_W-1:0] data_frame;
  logic [FRAME_W-1:0] train_frame;

  // Position 0 is sent first
  assign data_frame[0]         = 1'b1;
  assign data_frame[FRAME_W-1] = 1'b0;

  genvar g;
  generate
    for (g = 0; g < DATA_W; g++) begin : g_data
      assign data_frame[g+1] = word_i[g];
    end
    for (g = 0; g < FRAME_W; g++) begin : g_train
      assign train_frame[g] = fser_pkg::train_bit(g, ONES);
    end
  endgenerate

  assign frame_o = (kind_i == fser_pkg::FRAME_TRAIN) ? train_frame : data_frame;
endmodule

// File: rtl/fser_shifter.sv
module fser_shifter #(
  parameter int FRAME_W = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bit_en,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               ser_o,
  output logic               start_o
);
  logic [FRAME_W-2:0] rest_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rest_q  <= '0;
      ser_o   <= 1'b0;
      start_o <= 1'b0;
    end else begin
      start_o <= load_i;
      if (load_i) begin
        ser_o  <= frame_i[0];
        rest_q <= frame_i[FRAME_W-1:1];
      end else if (bit_en) begin
        ser_o  <= rest_q[0];
        rest_q <= {1'b0, rest_q[FRAME_W-2:1]};
      end
    end
  end
endmodule

// File: rtl/frame_serializer.sv
module frame_serializer #(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic [DATA_W-1:0] word_in,
  input  logic              train_req,
  output logic              ser_out,
  output logic              frame_start
);
  localparam int FRAME_W = DATA_W + 2;

  logic               load;
  logic [FRAME_W-1:0] frame;
  fser_pkg::frame_kind_e kind;

  assign kind = train_req ? fser_pkg::FRAME_TRAIN : fser_pkg::FRAME_DATA;

  fser_bit_counter #(.FRAME_W(FRAME_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .bit_en (bit_en),
    .load_o (load)
  );

  fser_frame_builder #(.DATA_W(DATA_W)) u_build (
    .word_i  (word_in),
    .kind_i  (kind),
    .frame_o (frame)
  );

  fser_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .bit_en  (bit_en),
    .load_i  (load),
    .frame_i (frame),
    .ser_o   (ser_out),
    .start_o (frame_start)
  );
endmodule

// File: rtl/fser_checker.sv
module fser_checker #(
  parameter int DATA_W = 10,
  localparam int FRAME_W = DATA_W + 2,
  localparam int CNT_W   = $clog2(FRAME_W + 1) + 1
) (
  input logic clk,
  input logic rst,
  input logic bit_en,
  input logic ser_out,
  input logic frame_start
);
  logic [CNT_W-1:0] en_cnt;
  logic             started;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_cnt  <= '0;
      started <= 1'b0;
    end else begin
      en_cnt  <= (frame_start ? '0 : en_cnt) + CNT_W'(bit_en);
      if (frame_start) started <= 1'b1;
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> (!ser_out && !frame_start));

  // R8
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> $stable(ser_out));

  // R3
  start_bit_chk: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> ser_out);

  // R5
  stop_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_start && started) |-> !$past(ser_out));

  // R2
  frame_len_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_start && started) |-> (en_cnt == CNT_W'(FRAME_W)));

  // R2
  single_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> !frame_start);
endmodule

bind frame_serializer fser_checker #(.DATA_W(DATA_W)) u_fser_chk (
  .clk         (clk),
  .rst         (rst),
  .bit_en      (bit_en),
  .ser_out     (ser_out),
  .frame_start (frame_start)
);

// File: tb/frame_serializer_bench.sv
module frame_serializer_bench;
  localparam int DATA_W  = 10;
  localparam int FRAME_W = DATA_W + 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bit_en = 1'b0;
  logic [DATA_W-1:0] word_in = '0;
  logic              train_req = 1'b0;
  logic              ser_out;
  logic              frame_start;

  int checks = 0;
  int errors = 0;

  logic exp_bit_q[$];
  logic exp_fs_q[$];
  string exp_tag_q[$];

  logic en_at_edge = 1'b0;
  logic last_ser   = 1'b0;
  bit   done       = 1'b0;

  always #5 clk = ~clk;

  frame_serializer #(.DATA_W(DATA_W)) u_frame_serializer (
    .clk         (clk),
    .rst         (rst),
    .bit_en      (bit_en),
    .word_in     (word_in),
    .train_req   (train_req),
    .ser_out     (ser_out),
    .frame_start (frame_start)
  );

  always @(posedge clk) en_at_edge <= bit_en && !rst;

  task automatic check(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // Monitor: pops one expected bit per enabled edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (en_at_edge) begin
        if (exp_bit_q.size() == 0) begin
          check("R2", 1'b1, 1'b0, "unexpected bit with empty queue");
        end else begin
          automatic logic  eb = exp_bit_q.pop_front();
          automatic logic  ef = exp_fs_q.pop_front();
          automatic string t  = exp_tag_q.pop_front();
          check(t, ser_out, eb, "serial bit");
          check("R2", frame_start, ef, "frame_start on enabled bit");
        end
      end else begin
        check("R8", ser_out, last_ser, "hold without enable");
        check("R2", frame_start, 1'b0, "frame_start idle");
      end
      last_ser = ser_out;
    end
  end

  // Driver: one frame, with gap idle clocks between enabled bits
  task automatic send_frame(input logic [DATA_W-1:0] w, input logic tr,
                            input int gap, input bit disturb);
    for (int p = 0; p < FRAME_W; p++) begin
      logic b;
      string t;
      if (tr) begin
        b = (p < FRAME_W / 2);
        t = "R6";
      end else if (p == 0) begin
        b = 1'b1; t = "R3";
      end else if (p == FRAME_W - 1) begin
        b = 1'b0; t = "R5";
      end else begin
        b = w[p-1]; t = disturb ? "R7" : "R4";
      end
      exp_bit_q.push_back(b);
      exp_fs_q.push_back(p == 0);
      exp_tag_q.push_back(t);
    end
    word_in   = w;
    train_req = tr;
    for (int p = 0; p < FRAME_W; p++) begin
      bit_en = 1'b1;
      @(negedge clk);
      bit_en = 1'b0;
      if (p == 0 && disturb) begin
        word_in   = ~w;
        train_req = ~tr;
      end
      for (int k = 0; k < gap; k++) @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", ser_out, 1'b0, "ser_out in reset");
    check("R1", frame_start, 1'b0, "frame_start in reset");
    rst = 1'b0;
    word_in = 10'h155;
    train_req = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", ser_out, 1'b0, "ser_out idle after reset");
    check("R9", frame_start, 1'b0, "no frame before first enable");

    send_frame(10'h3A5, 1'b0, 0, 1'b0);
    send_frame(10'h000, 1'b0, 0, 1'b0);
    send_frame(10'h3FF, 1'b0, 2, 1'b0);
    send_frame(10'h2C3, 1'b1, 0, 1'b0);
    send_frame(10'h201, 1'b0, 0, 1'b1);
    send_frame(10'h0F0, 1'b1, 3, 1'b1);
    send_frame(10'h1E1, 1'b1, 0, 1'b0);
    send_frame(10'h17E, 1'b0, 1, 1'b0);
    repeat (5) @(negedge clk);
    check("R2", exp_bit_q.size() == 0, 1'b1, "all expected bits consumed");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL R2 watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule